// File: doc/BRIEF.md
# Multi-Thread Time-Aware Gate Sequencer

This block opens and closes egress gates per output port and per traffic class to a programmed time plan. All ports share one linear table of timeslots. Each slot holds a duration, a bitmap of the ports it applies to, and a mask of the traffic classes it closes. Up to eight execution threads each walk their own contiguous range of that table, forever, one slot at a time.

Each thread has an entry point: a start index into the table and a start offset in delta units. A shared base time sets the origin. A thread starts when a free-running tick counter reaches the base time plus its offset. It walks from its entry index to its own end index, then wraps back to its entry index. One delta unit is `TICKS_PER_UNIT` clock ticks (25 by default). Software fills the tables through a write port while the sequencer is stopped, then issues a start command. A stop command idles every thread at once and opens every gate.

Top module: `gcs_sequencer`

## Requirements
- R1: Reset state:
  - every bit of `gate_open` reads 1;
  - `sched_stopped` reads 1;
  - `sched_started` and `port_collision` read 0;
  - `time_now` starts from 0 and rises by exactly one every clock.
- R2: Thread i launches at the clock edge on which `time_now` is at least base time plus (entry delta of i) × `TICKS_PER_UNIT`. Its first slot shows on the outputs from the next cycle.
- R3: A running thread holds each slot for (slot duration) × `TICKS_PER_UNIT` clocks, then moves to the next index. After the slot at its end index it returns to its entry index.
- R4: Gate encoding:
  - bit `p*8+c` of `gate_open` is 1 when class c of port p may send;
  - for a port whose bit is set in the current slot's destination bitmap, the classes are the inverse of that slot's closed mask;
  - a port that no running thread targets has all 8 classes open.
- R5: The active count field holds the number of threads minus one. A thread whose number is above that count never runs, and drives no gate.
- R6: Two running threads may target the same port in the same cycle. That port then gets the OR of both open sets, and `port_collision` rises one cycle later and stays set. An accepted start command clears it.
- R7: A `cmd_stop` pulse has the following effect from the next cycle:
  - all threads are idle;
  - `sched_stopped` reads 1 and `sched_started` reads 0;
  - every gate is open.
- R8: A write (`cfg_we`=1) takes effect only while `sched_stopped` is 1. Writes at any other time are dropped. The write kinds are:
  - kind 0 writes the slot at `cfg_addr`, with duration in `cfg_data[9:0]`, destination bitmap in `[13:10]` and closed mask in `[21:14]`;
  - kind 1 writes the entry point of thread `cfg_addr[2:0]`, with delta in `[9:0]` and start index in `[20:16]`;
  - kind 2 writes the end index of thread `cfg_addr[2:0]` from `[4:0]`;
  - kind 3 writes the base time (`cfg_addr`=0, `[31:0]`) or the active count (`cfg_addr`=1, `[2:0]`).
- R9: These writes are dropped and leave the stored entry unchanged:
  - a slot write whose duration is 0 or all ones (the legal range is 1 up to 2^10−2 units);
  - an entry-point write whose delta is 0.
- R10: `sched_started` is 1 exactly while at least one thread is executing slots. It stays 0 while armed threads still wait for their start time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse; accepted only while stopped |
| cmd_stop | input | 1 | Stop pulse; takes priority over start |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 2 | Write target kind (R8) |
| cfg_addr | input | 5 | Slot index, thread number or global selector |
| cfg_data | input | 32 | Write data |
| time_now | output | 32 | Free-running tick counter |
| gate_open | output | 32 | Gate enables, 8 classes per port, 4 ports |
| sched_started | output | 1 | Some thread is executing |
| sched_stopped | output | 1 | Sequencer is not armed |
| port_collision | output | 1 | Sticky same-port overlap flag |

## Verification
The assertions take the following for granted:
- `cmd_start` and `cmd_stop` are single-cycle pulses;
- a thread's entry index is not above its end index;
- end indices never decrease across threads.

The assertions rely on the stop command taking priority, so that stability of the configuration can be checked on any cycle spent armed. The stimulus follows these rules throughout:
- it programs only ordered ranges (thread 0 on slots 0–1, thread 1 on slots 2–3, all unused ends set to 3);
- it pulses commands for exactly one cycle;
- it picks base times well ahead of the counter when it starts, so every launch happens in a known cycle.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int GCS_PORTS = 4;
  localparam int GCS_TCS   = 8;
  localparam int GCS_DUR_W = 10;

  typedef struct packed {
    logic [GCS_TCS-1:0]   closed;
    logic [GCS_PORTS-1:0] dest;
    logic [GCS_DUR_W-1:0] dur;
  } slot_t;

  typedef enum logic [1:0] {TH_IDLE, TH_WAIT, TH_RUN} th_state_e;

  localparam logic [1:0] CFG_SLOT   = 2'd0;
  localparam logic [1:0] CFG_ENTRY  = 2'd1;
  localparam logic [1:0] CFG_END    = 2'd2;
  localparam logic [1:0] CFG_GLOBAL = 2'd3;

  // delta units to scheduler ticks
  function automatic logic [31:0] units_to_ticks(input logic [31:0] units,
                                                 input int unsigned tpu);
    return units * tpu;
  endfunction

  // a slot duration is legal when it is neither zero nor all ones
  function automatic logic dur_legal(input logic [GCS_DUR_W-1:0] d);
    return (d != '0) && (d != '1);
  endfunction
endpackage

// File: rtl/gcs_cfg_store.sv
module gcs_cfg_store import gcs_pkg::*; #(
  parameter int DEPTH  = 32,
  parameter int NTHR   = 8,
  parameter int TIME_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(NTHR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_allow,
  input  logic                 we,
  input  logic [1:0]           kind,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          data,
  output slot_t                slots     [DEPTH],
  output logic [GCS_DUR_W-1:0] ent_delta [NTHR],
  output logic [AW-1:0]        ent_addr  [NTHR],
  output logic [AW-1:0]        end_idx   [NTHR],
  output logic [TIME_W-1:0]    base_time,
  output logic [TW-1:0]        act_cnt
);
  logic  wr_ok;
  slot_t wslot;
  logic  slot_in_range;
  logic  [TW-1:0] tsel;

  assign wr_ok         = we && wr_allow;
  assign wslot         = slot_t'(data[$bits(slot_t)-1:0]);
  assign slot_in_range = int'(addr) < DEPTH;
  assign tsel          = addr[TW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      for (int t = 0; t < NTHR; t++) begin
        ent_delta[t] <= '0;
        ent_addr[t]  <= '0;
        end_idx[t]   <= '0;
      end
      base_time <= '0;
      act_cnt   <= '0;
    end else if (wr_ok) begin
      case (kind)
        CFG_SLOT:
          if (slot_in_range && dur_legal(wslot.dur)) slots[addr] <= wslot;
        CFG_ENTRY:
          if (data[GCS_DUR_W-1:0] != '0) begin
            ent_delta[tsel] <= data[GCS_DUR_W-1:0];
            ent_addr[tsel]  <= data[16 +: AW];
          end
        CFG_END:
          end_idx[tsel] <= data[AW-1:0];
        default: begin
          if (addr == AW'(0)) base_time <= data[TIME_W-1:0];
          else if (addr == AW'(1)) act_cnt <= data[TW-1:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/gcs_thread.sv
module gcs_thread import gcs_pkg::*; #(
  parameter int          DEPTH  = 32,
  parameter int          TIME_W = 32,
  parameter int unsigned TPU    = 25,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 halt,
  input  logic [TIME_W-1:0]    now,
  input  logic [TIME_W-1:0]    thr_time,
  input  logic [AW-1:0]        entry,
  input  logic [AW-1:0]        last,
  input  logic [GCS_DUR_W-1:0] dur_tbl [DEPTH],
  output logic                 running,
  output logic [AW-1:0]        idx,
  output logic                 adv
);
  th_state_e   st_q;
  logic [31:0] cnt_q;
  logic [AW-1:0] idx_q, nxt_idx;
  logic        reach;

  assign reach   = now >= thr_time;
  assign nxt_idx = (idx_q >= last) ? entry : idx_q + AW'(1);
  assign adv     = (st_q == TH_RUN) && (cnt_q == 32'd0);
  assign running = (st_q == TH_RUN);
  assign idx     = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TH_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (halt) begin
      st_q <= TH_IDLE;
    end else if (launch) begin
      st_q <= TH_WAIT;
    end else begin
      case (st_q)
        TH_WAIT:
          if (reach) begin
            st_q  <= TH_RUN;
            idx_q <= entry;
            cnt_q <= units_to_ticks(32'(dur_tbl[entry]), TPU) - 32'd1;
          end
        TH_RUN:
          if (adv) begin
            idx_q <= nxt_idx;
            cnt_q <= units_to_ticks(32'(dur_tbl[nxt_idx]), TPU) - 32'd1;
          end else begin
            cnt_q <= cnt_q - 32'd1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gcs_gate_merge.sv
module gcs_gate_merge import gcs_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int NTHR  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int GW = GCS_PORTS * GCS_TCS
) (
  input  logic                 active     [NTHR],
  input  logic [AW-1:0]        idx        [NTHR],
  input  logic [GCS_PORTS-1:0] dest_tbl   [DEPTH],
  input  logic [GCS_TCS-1:0]   closed_tbl [DEPTH],
  output logic [GW-1:0]        gate_open,
  output logic                 clash
);
  logic               seen;
  logic [GCS_TCS-1:0] acc;

  always_comb begin
    clash     = 1'b0;
    gate_open = '1;
    seen      = 1'b0;
    acc       = '0;
    for (int p = 0; p < GCS_PORTS; p++) begin
      seen = 1'b0;
      acc  = '0;
      for (int t = 0; t < NTHR; t++) begin
        if (active[t] && dest_tbl[idx[t]][p]) begin
          if (seen) clash = 1'b1;
          seen = 1'b1;
          acc  = acc | ~closed_tbl[idx[t]];
        end
      end
      gate_open[p*GCS_TCS +: GCS_TCS] = seen ? acc : '1;
    end
  end
endmodule

// File: rtl/gcs_sequencer.sv
module gcs_sequencer import gcs_pkg::*; #(
  parameter int          TBL_DEPTH      = 32,
  parameter int          NUM_THREADS    = 8,
  parameter int          TIME_W         = 32,
  parameter int unsigned TICKS_PER_UNIT = 25,
  localparam int AW = $clog2(TBL_DEPTH),
  localparam int TW = $clog2(NUM_THREADS),
  localparam int GW = GCS_PORTS * GCS_TCS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [31:0]       cfg_data,
  output logic [TIME_W-1:0] time_now,
  output logic [GW-1:0]     gate_open,
  output logic              sched_started,
  output logic              sched_stopped,
  output logic              port_collision
);
  slot_t                slots      [TBL_DEPTH];
  logic [GCS_DUR_W-1:0] dur_tbl    [TBL_DEPTH];
  logic [GCS_PORTS-1:0] dest_tbl   [TBL_DEPTH];
  logic [GCS_TCS-1:0]   closed_tbl [TBL_DEPTH];
  logic [GCS_DUR_W-1:0] ent_delta  [NUM_THREADS];
  logic [AW-1:0]        ent_addr   [NUM_THREADS];
  logic [AW-1:0]        end_idx    [NUM_THREADS];
  logic [TIME_W-1:0]    thr_time   [NUM_THREADS];
  logic                 thr_run    [NUM_THREADS];
  logic [AW-1:0]        thr_idx    [NUM_THREADS];
  logic [NUM_THREADS-1:0] thr_adv, thr_launch, thr_run_vec;
  logic [TIME_W-1:0]    base_time_q;
  logic [TW-1:0]        act_cnt;
  logic [TIME_W-1:0]    now_q;
  logic                 armed_q, coll_q;
  logic                 start_go, clash_w;

  // named events for the checker
  assign start_go = cmd_start && !cmd_stop && !armed_q;

  gcs_cfg_store #(.DEPTH(TBL_DEPTH), .NTHR(NUM_THREADS), .TIME_W(TIME_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_allow(!armed_q), .we(cfg_we), .kind(cfg_kind),
    .addr(cfg_addr), .data(cfg_data), .slots(slots), .ent_delta(ent_delta),
    .ent_addr(ent_addr), .end_idx(end_idx), .base_time(base_time_q), .act_cnt(act_cnt)
  );

  for (genvar s = 0; s < TBL_DEPTH; s++) begin : g_split
    assign dur_tbl[s]    = slots[s].dur;
    assign dest_tbl[s]   = slots[s].dest;
    assign closed_tbl[s] = slots[s].closed;
  end

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
    assign thr_time[i]    = base_time_q +
                            TIME_W'(units_to_ticks(32'(ent_delta[i]), TICKS_PER_UNIT));
    assign thr_launch[i]  = start_go && (act_cnt >= TW'(i));
    assign thr_run_vec[i] = thr_run[i];
    gcs_thread #(.DEPTH(TBL_DEPTH), .TIME_W(TIME_W), .TPU(TICKS_PER_UNIT)) th_i (
      .clk(clk), .rst_n(rst_n), .launch(thr_launch[i]), .halt(cmd_stop),
      .now(now_q), .thr_time(thr_time[i]), .entry(ent_addr[i]), .last(end_idx[i]),
      .dur_tbl(dur_tbl), .running(thr_run[i]), .idx(thr_idx[i]), .adv(thr_adv[i])
    );
  end

  gcs_gate_merge #(.DEPTH(TBL_DEPTH), .NTHR(NUM_THREADS)) merge_i (
    .active(thr_run), .idx(thr_idx), .dest_tbl(dest_tbl), .closed_tbl(closed_tbl),
    .gate_open(gate_open), .clash(clash_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q   <= '0;
      armed_q <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      now_q <= now_q + TIME_W'(1);
      if (cmd_stop)      armed_q <= 1'b0;
      else if (start_go) armed_q <= 1'b1;
      if (start_go)     coll_q <= 1'b0;
      else if (clash_w) coll_q <= 1'b1;
    end
  end

  assign time_now       = now_q;
  assign sched_started  = |thr_run_vec;
  assign sched_stopped  = !armed_q;
  assign port_collision = coll_q;
endmodule

// File: rtl/gcs_sequencer_chk.sv
module gcs_sequencer_chk #(
  parameter int TIME_W = 32,
  parameter int GW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_stop,
  input logic              start_go,
  input logic              clash_w,
  input logic [TIME_W-1:0] time_now,
  input logic [TIME_W-1:0] base_time_q,
  input logic [GW-1:0]     gate_open,
  input logic              sched_started,
  input logic              sched_stopped,
  input logic              port_collision
);
  // R1
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> time_now == $past(time_now) + TIME_W'(1));
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> sched_stopped && !sched_started && (&gate_open));
  // R7
  stopped_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_stopped |-> (&gate_open));
  // R10
  started_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_started |-> !sched_stopped);
  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_stopped |=> $stable(base_time_q));
  // R6
  coll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_w && !start_go |=> port_collision);
  // R6
  coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_collision && !start_go |=> port_collision);
endmodule

bind gcs_sequencer gcs_sequencer_chk #(.TIME_W(TIME_W), .GW(GW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop), .start_go(start_go),
  .clash_w(clash_w), .time_now(time_now), .base_time_q(base_time_q),
  .gate_open(gate_open), .sched_started(sched_started),
  .sched_stopped(sched_stopped), .port_collision(port_collision)
);

// File: tb/gcs_sequencer_tb_top.sv
module gcs_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_stop = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic [31:0] time_now, gate_open;
  logic        sched_started, sched_stopped, port_collision;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  gcs_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .time_now(time_now), .gate_open(gate_open), .sched_started(sched_started),
    .sched_stopped(sched_stopped), .port_collision(port_collision)
  );

  // run 1: thread0 slots 0-1 from base+1 unit, thread1 slots 2-3 from base+3 units
  localparam int          NV = 8;
  localparam int unsigned V_T [NV] = '{1025, 1026, 1075, 1076, 1100, 1101, 1126, 1151};
  localparam logic [31:0] V_G [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFF0,
                                       32'hFFFF_FE0F, 32'hFFFF_FE0F, 32'hFF7F_FFF0,
                                       32'hFFFF_FEF0, 32'hFF7F_FF0F};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at t=%0d", req, act, exp, time_now);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_kind = k; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic pulse_stop();
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
  endtask

  task automatic wait_until(input int unsigned t);
    while (time_now != t) @(negedge clk);
  endtask

  function automatic logic [31:0] slot_word(input logic [7:0] closed,
                                            input logic [3:0] dest, input logic [9:0] dur);
    return {10'd0, closed, dest, dur};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned t0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gates", gate_open, 32'hFFFF_FFFF);
    chk("R1 stopped", 32'(sched_stopped), 32'd1);
    chk("R1 started", 32'(sched_started), 32'd0);
    chk("R1 collision", 32'(port_collision), 32'd0);
    t0 = time_now;
    @(negedge clk);
    chk("R1 counter", time_now, t0 + 1);

    wr(2'd0, 5'd0, slot_word(8'h0F, 4'b0001, 10'd2));
    wr(2'd0, 5'd1, slot_word(8'hF0, 4'b0001, 10'd1));
    wr(2'd0, 5'd2, slot_word(8'h01, 4'b0010, 10'd1));
    wr(2'd0, 5'd3, slot_word(8'h80, 4'b0100, 10'd1));
    wr(2'd1, 5'd0, (32'd0 << 16) | 32'd1);
    wr(2'd1, 5'd1, (32'd2 << 16) | 32'd3);
    wr(2'd2, 5'd0, 32'd1);
    for (int t = 1; t < 8; t++) wr(2'd2, 5'(t), 32'd3);
    wr(2'd3, 5'd0, 32'd1000);
    wr(2'd3, 5'd1, 32'd1);
    pulse_start();
    // R8: write while armed must be dropped
    wr(2'd0, 5'd0, slot_word(8'hFF, 4'b0001, 10'd2));

    // R2 R3 R4 vector walk
    for (int v = 0; v < NV; v++) begin
      wait_until(V_T[v]);
      chk("R3 vector", gate_open, V_G[v]);
      if (v == 0) chk("R10 waiting", 32'(sched_started), 32'd0);
      if (v == 1) begin
        chk("R10 running", 32'(sched_started), 32'd1);
        chk("R8 armed write dropped", gate_open, 32'hFFFF_FFF0);
      end
    end

    pulse_stop();
    chk("R7 stopped", 32'(sched_stopped), 32'd1);
    chk("R7 started", 32'(sched_started), 32'd0);
    chk("R7 gates", gate_open, 32'hFFFF_FFFF);

    // R9: illegal writes, then a same-port overlap for R6
    wr(2'd0, 5'd1, slot_word(8'h00, 4'b0001, 10'd0));
    wr(2'd0, 5'd1, slot_word(8'h00, 4'b0001, 10'h3FF));
    wr(2'd1, 5'd0, (32'd3 << 16) | 32'd0);
    wr(2'd0, 5'd3, slot_word(8'h80, 4'b0001, 10'd1));
    wr(2'd3, 5'd0, 32'd3000);
    pulse_start();
    wait_until(3025);
    chk("R9 entry delta 0 dropped", gate_open, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 entry delta 0 dropped", gate_open, 32'hFFFF_FFF0);
    wait_until(3076);
    chk("R9 slot dur dropped", gate_open, 32'hFFFF_FE0F);
    wait_until(3100);
    chk("R6 no collision yet", 32'(port_collision), 32'd0);
    @(negedge clk);
    chk("R6 merged gates", gate_open, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R6 collision flag", 32'(port_collision), 32'd1);

    pulse_stop();
    chk("R6 flag kept over stop", 32'(port_collision), 32'd1);
    wr(2'd3, 5'd1, 32'd0);
    wr(2'd3, 5'd0, 32'd5000);
    pulse_start();
    chk("R6 start clears", 32'(port_collision), 32'd0);
    wait_until(5076);
    chk("R5 thread1 idle", gate_open, 32'hFFFF_FF0F);
    wait_until(5101);
    chk("R5 thread1 idle", gate_open, 32'hFFFF_FFF0);
    @(negedge clk);
    chk("R5 no collision", 32'(port_collision), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule